// File: doc/BRIEF.md
# Shared Interrupt Router

This block is the global routing stage of a small multiprocessor interrupt controller. Interrupt IDs 0 to 31 are handled per CPU: software interrupts use 0 to 15 and private interrupts use 16 to 31. Every ID from 32 upward is a common interrupt that arrives on a shared input line. For each common interrupt, the block holds one destination word. That word names a single target CPU and carries a delivery-enable flag. Software sets the word with a write-only register bus.

On every clock, each common input is sent to the pending vector of the one CPU that its word selects. The input is dropped when delivery is off or when the named CPU does not exist. The pending vectors feed the per-CPU local interfaces, which handle priority, acknowledge and the private sources.

Routing is level based. A pending bit is the registered copy of its input line, gated by the route that held in the same cycle. A new destination therefore takes effect on the first clock after the write that sets it.

Top module: `intc_dist`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every bit of `pend_o` is 0. All routes are disabled, whatever the source lines are doing.
- R2: A write to byte address 0x1000 + 4*(ID-32) configures common interrupt ID. Data bit 31 = 1 enables delivery. Data bits [7:0] = c with c < NUM_CPU selects CPU c. After the write, `pend_o` bit c*(NUM_IDS-32) + (ID-32) carries that source, and no other CPU's bit carries it.
- R3: A destination word written with bit 31 = 0 delivers its source to no CPU. This holds even when the source was enabled before.
- R4: A destination word whose bits [7:0] hold a value greater than or equal to NUM_CPU delivers its source to no CPU.
- R5: `pend_o` bits follow their source line with one cycle of latency. A bit rises one clock after its source rises and falls one clock after it falls.
- R6: A write is ignored, and leaves every route unchanged, in any of these cases: the address is below 0x1000, the address is at or beyond 0x1000 + 4*(NUM_IDS-32), or address bits [1:0] are not 00.
- R7: The `pend_o` value captured on the clock edge that also takes a destination write still uses the old route. The new route applies from the following edge.
- R8: Data bits [30:8] of a destination write have no effect on routing.
- R9: In any cycle, each common source is pending at no more than one CPU.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe, one write per cycle |
| wr_addr_i | input | ADDR_W (15) | Byte address within the 0x8000-byte global window |
| wr_data_i | input | 32 | Write data: bit 31 enable, bits [7:0] CPU index |
| src_i | input | NUM_IDS-32 (224) | Level inputs of the common interrupts; bit k is ID 32+k |
| pend_o | output | NUM_CPU*(NUM_IDS-32) (896) | Pending vectors; bit c*(NUM_IDS-32)+k is ID 32+k at CPU c |

## Verification
The assertions assume a single writer. They also assume that `wr_addr_i` and `wr_data_i` are stable and defined whenever `wr_en_i` is high, and that source lines change only between clock edges. The stimulus drives every input one nanosecond after a rising edge, so each value is settled well before the next edge. It raises the write strobe for exactly one cycle per register write. The stimulus probes the first and last table entries, a misaligned address that would otherwise alias entry 0, and addresses just outside the table and the window. It also exercises indices just past the CPU count and writes that land while the affected source is active.

// File: rtl/intc_dist_pkg.sv
package intc_dist_pkg;
  // first ID handled by the global router; lower IDs stay per CPU
  localparam int unsigned FIRST_COMMON_ID = 32;
  // byte offset of the destination table in the global window
  localparam int unsigned DEST_TABLE_BASE = 32'h1000;
  // each destination word occupies four bytes
  localparam int unsigned DEST_STRIDE     = 4;
  // register data width and position of the delivery flag
  localparam int unsigned REG_W           = 32;
  localparam int unsigned DEST_EN_BIT     = 31;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/intc_dist_wdec.sv
module intc_dist_wdec
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned NUM_COMMON  = 224,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned IDX_FIELD_W = 8,
  localparam int unsigned CPU_W      = idx_width(NUM_CPU),
  localparam int unsigned SRC_W      = idx_width(NUM_COMMON)
) (
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [REG_W-1:0]     wr_data_i,
  output logic                 hit_o,
  output logic [SRC_W-1:0]     idx_o,
  output logic                 vld_o,
  output logic [CPU_W-1:0]     cpu_o
);
  localparam logic [ADDR_W:0] LO_A = (ADDR_W+1)'(DEST_TABLE_BASE);
  localparam logic [ADDR_W:0] HI_A = (ADDR_W+1)'(DEST_TABLE_BASE + DEST_STRIDE*NUM_COMMON);

  logic [ADDR_W:0]        addr_ext;
  logic [ADDR_W-1:0]      offset;
  logic [IDX_FIELD_W-1:0] cpu_field;
  logic                   in_table;
  logic                   aligned;

  assign addr_ext  = {1'b0, wr_addr_i};
  assign offset    = wr_addr_i - LO_A[ADDR_W-1:0];
  assign in_table  = (addr_ext >= LO_A) && (addr_ext < HI_A);
  assign aligned   = (wr_addr_i[1:0] == 2'b00);
  assign cpu_field = wr_data_i[IDX_FIELD_W-1:0];

  assign hit_o = wr_en_i && in_table && aligned;
  assign idx_o = offset[SRC_W+1:2];
  assign vld_o = wr_data_i[DEST_EN_BIT] && (cpu_field < IDX_FIELD_W'(NUM_CPU));
  assign cpu_o = cpu_field[CPU_W-1:0];

  // fields with no routing meaning
  logic unused_bits;
  assign unused_bits = ^{wr_data_i[DEST_EN_BIT-1:IDX_FIELD_W],
                         offset[ADDR_W-1:SRC_W+2], offset[1:0]};
endmodule

// File: rtl/intc_dist_table.sv
module intc_dist_table
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_COMMON = 224,
  localparam int unsigned CPU_W     = idx_width(NUM_CPU),
  localparam int unsigned SRC_W     = idx_width(NUM_COMMON)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          hit_i,
  input  logic [SRC_W-1:0]              idx_i,
  input  logic                          vld_i,
  input  logic [CPU_W-1:0]              cpu_i,
  output logic [NUM_COMMON-1:0]         vld_o,
  output logic [NUM_COMMON*CPU_W-1:0]   cpu_o
);
  for (genvar s = 0; s < NUM_COMMON; s++) begin : g_entry
    logic             wr_ce;
    logic             vld_d, vld_q;
    logic [CPU_W-1:0] cpu_d, cpu_q;

    assign wr_ce = hit_i && (idx_i == SRC_W'(s));

    always_comb begin
      vld_d = vld_q;
      cpu_d = cpu_q;
      if (wr_ce) begin
        vld_d = vld_i;
        cpu_d = cpu_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        cpu_q <= '0;
      end else begin
        vld_q <= vld_d;
        cpu_q <= cpu_d;
      end
    end

    assign vld_o[s]                  = vld_q;
    assign cpu_o[s*CPU_W +: CPU_W]   = cpu_q;
  end
endmodule

// File: rtl/intc_dist_fanout.sv
module intc_dist_fanout
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned NUM_COMMON = 224,
  localparam int unsigned CPU_W     = idx_width(NUM_CPU)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_COMMON-1:0]         src_i,
  input  logic [NUM_COMMON-1:0]         vld_i,
  input  logic [NUM_COMMON*CPU_W-1:0]   cpu_i,
  output logic [NUM_CPU*NUM_COMMON-1:0] pend_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_COMMON-1:0] sel;
    logic [NUM_COMMON-1:0] pend_d, pend_q;

    for (genvar s = 0; s < NUM_COMMON; s++) begin : g_sel
      assign sel[s] = (cpu_i[s*CPU_W +: CPU_W] == CPU_W'(c));
    end

    always_comb begin
      pend_d = src_i & vld_i & sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
      end else begin
        pend_q <= pend_d;
      end
    end

    assign pend_o[c*NUM_COMMON +: NUM_COMMON] = pend_q;
  end
endmodule

// File: rtl/intc_dist.sv
module intc_dist
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned NUM_IDS     = 256,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned IDX_FIELD_W = 8,
  localparam int unsigned NUM_COMMON = NUM_IDS - FIRST_COMMON_ID,
  localparam int unsigned CPU_W      = idx_width(NUM_CPU),
  localparam int unsigned SRC_W      = idx_width(NUM_COMMON)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [REG_W-1:0]              wr_data_i,
  input  logic [NUM_COMMON-1:0]         src_i,
  output logic [NUM_CPU*NUM_COMMON-1:0] pend_o
);
  logic                        dec_hit;
  logic [SRC_W-1:0]            dec_idx;
  logic                        dec_vld;
  logic [CPU_W-1:0]            dec_cpu;
  logic [NUM_COMMON-1:0]       route_vld;
  logic [NUM_COMMON*CPU_W-1:0] route_cpu;

  intc_dist_wdec #(
    .NUM_CPU(NUM_CPU), .NUM_COMMON(NUM_COMMON),
    .ADDR_W(ADDR_W), .IDX_FIELD_W(IDX_FIELD_W)
  ) u_wdec (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .hit_o    (dec_hit),
    .idx_o    (dec_idx),
    .vld_o    (dec_vld),
    .cpu_o    (dec_cpu)
  );

  intc_dist_table #(
    .NUM_CPU(NUM_CPU), .NUM_COMMON(NUM_COMMON)
  ) u_table (
    .clk  (clk),
    .rst_n(rst_n),
    .hit_i(dec_hit),
    .idx_i(dec_idx),
    .vld_i(dec_vld),
    .cpu_i(dec_cpu),
    .vld_o(route_vld),
    .cpu_o(route_cpu)
  );

  intc_dist_fanout #(
    .NUM_CPU(NUM_CPU), .NUM_COMMON(NUM_COMMON)
  ) u_fanout (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .vld_i (route_vld),
    .cpu_i (route_cpu),
    .pend_o(pend_o)
  );
endmodule

// File: rtl/intc_dist_chk.sv
module intc_dist_chk
  import intc_dist_pkg::*;
#(
  parameter int unsigned NUM_CPU     = 4,
  parameter int unsigned NUM_IDS     = 256,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned IDX_FIELD_W = 8,
  localparam int unsigned NC         = NUM_IDS - FIRST_COMMON_ID,
  localparam int unsigned CPU_W      = idx_width(NUM_CPU),
  localparam int unsigned SRC_W      = idx_width(NC)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [REG_W-1:0]      wr_data_i,
  input logic [NC-1:0]         src_i,
  input logic [NUM_CPU*NC-1:0] pend_o,
  input logic [NC-1:0]         route_vld,
  input logic [NC*CPU_W-1:0]   route_cpu
);
  logic              in_win;
  logic [ADDR_W-1:0] off_c;
  logic [SRC_W-1:0]  idx_now, last_idx;
  logic              cpu_ok;

  assign in_win = (int'(wr_addr_i) >= int'(DEST_TABLE_BASE)) &&
                  (int'(wr_addr_i) < int'(DEST_TABLE_BASE + DEST_STRIDE*NC)) &&
                  (wr_addr_i[1:0] == 2'b00);
  assign off_c   = wr_addr_i - ADDR_W'(DEST_TABLE_BASE);
  assign idx_now = off_c[SRC_W+1:2];
  assign cpu_ok  = (int'(wr_data_i[IDX_FIELD_W-1:0]) < int'(NUM_CPU));

  logic unused_chk;
  assign unused_chk = ^{off_c[ADDR_W-1:SRC_W+2], off_c[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_idx <= '0;
    else        last_idx <= idx_now;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pend_o == '0) && (route_vld == '0));

  assert_ignore_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !in_win) |=> $stable(route_vld) && $stable(route_cpu));

  assert_disable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && in_win && !wr_data_i[DEST_EN_BIT]) |=> !route_vld[last_idx]);

  assert_bad_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && in_win && !cpu_ok) |=> !route_vld[last_idx]);

  // also covers R8: upper data bits do not block acceptance
  assert_accept_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && in_win && wr_data_i[DEST_EN_BIT] && cpu_ok) |=>
      route_vld[last_idx] &&
      (route_cpu[last_idx*CPU_W +: CPU_W] == $past(wr_data_i[CPU_W-1:0])));

  for (genvar s = 0; s < NC; s++) begin : g_src
    logic [NUM_CPU-1:0] col;
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_col
      assign col[c] = pend_o[c*NC + s];

      assert_target_cpu_R2: assert property (@(posedge clk) disable iff (!rst_n)
        col[c] |-> ($past(route_cpu[s*CPU_W +: CPU_W]) == CPU_W'(c)));
    end

    assert_single_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));

    assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|col) |-> $past(src_i[s] && route_vld[s]));

    assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(src_i[s] && route_vld[s]) |-> (|col));
  end
endmodule

bind intc_dist intc_dist_chk #(
  .NUM_CPU(NUM_CPU), .NUM_IDS(NUM_IDS),
  .ADDR_W(ADDR_W), .IDX_FIELD_W(IDX_FIELD_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .src_i    (src_i),
  .pend_o   (pend_o),
  .route_vld(route_vld),
  .route_cpu(route_cpu)
);

// File: tb/intc_dist_tb_top.sv
`timescale 1ns/1ps
module intc_dist_tb_top;
  localparam int NCPU = 4;
  localparam int NIDS = 256;
  localparam int NC   = NIDS - 32;
  localparam int AW   = 15;
  localparam int W    = NCPU * NC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [NC-1:0] src;
  logic [W-1:0]  pend;

  always #2 clk = ~clk;  // 250 MHz

  intc_dist #(.NUM_CPU(NCPU), .NUM_IDS(NIDS), .ADDR_W(AW), .IDX_FIELD_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .src_i(src), .pend_o(pend)
  );

  typedef struct {
    int           due;
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;
  bit m_en[NC];
  int m_cpu[NC];

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare the design output against queued expectations
  always @(negedge clk) begin : monitor
    item_t it;
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      it = sbq.pop_front();
      n_cmp++;
      if (pend !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, pend, it.exp);
      end
    end
  end

  function automatic logic [AW-1:0] dest_addr(input int k);
    return AW'(32'h1000 + 4*k);
  endfunction

  function automatic logic [31:0] dest_word(input bit en, input int cpu);
    return {en, 23'h0, 8'(cpu)};
  endfunction

  function automatic logic [NC-1:0] one_src(input int k);
    logic [NC-1:0] v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

  // driver: compute expectation from the model, push it, then drive
  task automatic step(input logic [NC-1:0] s, input bit we,
                      input logic [AW-1:0] a, input logic [31:0] d,
                      input string tag);
    logic [W-1:0] e;
    int ai;
    int k;
    @(posedge clk);
    #1;
    e = '0;
    for (int i = 0; i < NC; i++)
      if (s[i] && m_en[i]) e[m_cpu[i]*NC + i] = 1'b1;
    sbq.push_back('{due: cyc + 1, exp: e, tag: tag});
    ai = int'(a);
    if (we && rst_n && ai >= 32'h1000 && ai < 32'h1000 + 4*NC && a[1:0] == 2'b00) begin
      k = (ai - 32'h1000) / 4;
      m_en[k]  = d[31] && (int'(d[7:0]) < NCPU);
      m_cpu[k] = int'(d[7:0]);
    end
    src     = s;
    wr_en   = we;
    wr_addr = a;
    wr_data = d;
  endtask

  task automatic idle(input logic [NC-1:0] s, input string tag);
    step(s, 1'b0, '0, '0, tag);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [NC-1:0] all1;
    logic [NC-1:0] pat;
    all1 = '1;
    pat  = {7{32'hA5C3_0F96}};
    for (int i = 0; i < NC; i++) begin m_en[i] = 1'b0; m_cpu[i] = 0; end
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; src = '0;

    // R1: reset holds outputs low even with all sources active
    idle(all1, "R1 in reset");
    idle(all1, "R1 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    idle(all1, "R1 after reset, routes off");
    idle(all1, "R1 after reset, routes off");

    // R2: first and last table entries
    step('0, 1'b1, dest_addr(0), dest_word(1, 2), "R2 program id32");
    idle(one_src(0), "R2 id32 to cpu2");
    step('0, 1'b1, dest_addr(NC-1), dest_word(1, 3), "R2 program last id");
    idle(one_src(NC-1), "R2 last id to cpu3");

    // R3: delivery flag clear
    step(one_src(5), 1'b1, dest_addr(5), dest_word(0, 1), "R3 write disabled");
    idle(one_src(5), "R3 disabled source dropped");

    // R4: out-of-range CPU index
    step('0, 1'b1, dest_addr(6), dest_word(1, NCPU), "R4 program idx=NCPU");
    idle(one_src(6), "R4 idx=NCPU dropped");
    step('0, 1'b1, dest_addr(6), dest_word(1, 200), "R4 program idx=200");
    idle(one_src(6), "R4 idx=200 dropped");

    // R8: upper data bits ignored
    step('0, 1'b1, dest_addr(7), 32'hFFFF_FF01, "R8 program with junk bits");
    idle(one_src(7), "R8 junk bits ignored, cpu1");

    // R6: writes outside the table or misaligned
    step('0, 1'b1, AW'(16'h1002), dest_word(0, 0), "R6 misaligned write");
    step('0, 1'b1, AW'(16'h0FFC), dest_word(1, 0), "R6 below table");
    step('0, 1'b1, AW'(32'h1000 + 4*NC), dest_word(1, 0), "R6 past table");
    step('0, 1'b1, AW'(16'h7FFC), dest_word(1, 1), "R6 window end");
    idle(one_src(0) | one_src(NC-1), "R6 routes intact");

    // R5: level following
    idle(one_src(0), "R5 level high");
    idle('0, "R5 level low");
    idle(one_src(0), "R5 level high again");
    idle(one_src(0), "R5 level held");

    // R7: reroute while source active
    step(one_src(0), 1'b1, dest_addr(0), dest_word(1, 1), "R7 write cycle uses old route");
    idle(one_src(0), "R7 new route cpu1");

    // R3: disable a live route
    step(one_src(0), 1'b1, dest_addr(0), dest_word(0, 1), "R3 disable live route");
    idle(one_src(0), "R3 dropped after disable");

    // R9: program every source, then run patterns
    for (int k = 0; k < NC; k++)
      step(pat, 1'b1, dest_addr(k), dest_word(1, (k * 7) % NCPU), "R9 bulk program");
    idle(all1, "R9 all sources single cpu");
    idle(pat, "R9 pattern");
    idle(~pat, "R9 inverse pattern");
    idle('0, "R9 quiet");

    repeat (4) @(posedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule